// File: doc/BRIEF.md
# Attribute Table Entry Responder

This block keeps a small, fixed table that describes the attributes of a memory device. The table has seven entries. Entry 0 is a table header. Entries 1 to 6 are typed subtables. When reset is released, the block reads every byte of every entry, one byte per clock. From that pass it fills in the header's total byte count and its checksum byte, so the table contents can be changed through parameters without recomputing either field by hand.

After the start-up pass, software or a transport layer sends read requests as parsed fields. Each request carries an entry handle. The block answers with a dword stream using valid/ready handshaking. The stream is a two-dword response header followed by the requested entry's bytes. The second header dword holds the handle of the next entry, so a reader can walk the whole table by following the returned handles until the all-ones end marker comes back.

Top module: `attr_tbl_resp`

## Requirements
- R1: Following reset, `req_ready` and `rsp_valid` stay low while the start-up pass reads the 156 table bytes, one byte per clock. `req_ready` rises once that pass completes, and a request offered during the pass produces no response.
- R2: Handle 0 returns the 16-byte header. Handles 1 to 6 return subtables of type 0 to 5, sized 24, 24, 20, 8, 24 and 40 bytes. Each subtable's first bytes are its type (byte 0), a zero reserved byte (byte 1) and its byte length as a 16-bit value (bytes 2 to 3).
- R3: Header bytes 0 to 3 hold the table's total byte length, 156, counting all seven entries including the header.
- R4: Header byte 4 holds revision 1 and header byte 5 holds the checksum. The checksum makes the 8-bit sum of every byte of all seven entries equal to zero.
- R5: Response dword 0 carries the vendor ID 0x1E98 in bits [15:0], the object type 2 in bits [23:16], and the response length in dwords, (8 + entry bytes) / 4, in bits [31:24].
- R6: Response dword 1 carries a request code of 0 in bits [7:0] and a table type of 0 in bits [15:8]. Bits [31:16] hold the next handle: the requested handle plus one when that sum is below 7, and 0xFFFF otherwise.
- R7: A request with a handle of 7 or more gets a two-dword response: length 2 and next handle 0xFFFF.
- R8: Entry byte 4k+i appears in bits [8i+7:8i] of entry dword k, which is response dword k+2. Multi-byte fields are therefore little-endian.
- R9: By default, the memory-range subtable (handle 1) has base 0 in bytes 8 to 15 and length 0x40000 in bytes 16 to 23. The switch-latency subtable (handle 6) holds three 8-byte records at byte 16+8k, each with port IDs k and k in its first and second 16-bit fields and zero elsewhere.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_last` hold steady. `rsp_last` is high on exactly the final dword of each response.
- R11: Each accepted request yields exactly one response. `req_ready` stays low while a response is in progress, and a request offered then is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_handle | input | 16 | Entry handle being requested |
| rsp_valid | output | 1 | Response dword present |
| rsp_ready | input | 1 | Consumer takes the dword |
| rsp_data | output | 32 | Response dword |
| rsp_last | output | 1 | Final dword of the response |

## Verification
The table is walked by chaining the returned handles from 0 up to the end marker. This shows that the next-handle sequence is correct, and it adds up the received entry bytes so that the total length and the zero checksum are checked independently of the header fields. Single handles are then requested in a scrambled order under random consumer stalls; this separates correct per-entry selection and data holding from a design that only works in order or at full rate. Handles 7, 8, 0x1234 and 0xFFFF probe the out-of-range path. Requests offered during the start-up pass and during a stalled response show whether the block drops them instead of queueing them.

// File: rtl/attr_tbl_pkg.sv
package attr_tbl_pkg;

   localparam int unsigned NUM_ENT   = 7;
   localparam int unsigned HANDLE_W  = 16;
   localparam int unsigned WORD_W    = 4;

   // byte size of each entry
   function automatic logic [7:0] ent_bytes(input logic [2:0] e);
      logic [7:0] n;
      case (e)
         3'd0:       n = 8'd16;
         3'd1, 3'd2: n = 8'd24;
         3'd3:       n = 8'd20;
         3'd4:       n = 8'd8;
         3'd5:       n = 8'd24;
         3'd6:       n = 8'd40;
         default:    n = 8'd0;
      endcase
      return n;
   endfunction

   function automatic logic [31:0] total_bytes();
      logic [31:0] t;
      t = '0;
      for (int i = 0; i < int'(NUM_ENT); i++) t = t + {24'd0, ent_bytes(3'(i))};
      return t;
   endfunction

   // constant table byte; header length and checksum bytes read as zero
   function automatic logic [7:0] tbl_byte(input logic [2:0]  e,
                                           input logic [5:0]  b,
                                           input logic [63:0] mem_len);
      logic [7:0]  v;
      logic [5:0]  off;
      logic [63:0] sh;
      v   = 8'd0;
      off = b - 6'd16;
      sh  = mem_len >> {b[2:0], 3'b000};
      if (e == 3'd0) begin
         if (b == 6'd4) v = 8'd1;
      end else if (e < 3'd7) begin
         if (b == 6'd0) v = {5'd0, e - 3'd1};
         if (b == 6'd2) v = ent_bytes(e);
         if (e == 3'd1 && b >= 6'd16 && b < 6'd24) v = sh[7:0];
         if (e == 3'd6 && b >= 6'd16 && (off[2:0] == 3'd0 || off[2:0] == 3'd2))
            v = {5'd0, off[5:3]};
      end
      return v;
   endfunction

endpackage

// File: rtl/attr_tbl_walker.sv
module attr_tbl_walker
   import attr_tbl_pkg::*;
#(
   parameter logic [63:0] MEM_RANGE_LEN = 64'h40000
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic        done_o,
   output logic [31:0] tot_len_o,
   output logic [7:0]  csum_o
);
   localparam logic [31:0] TOTAL = total_bytes();

   logic [2:0]  e_q;
   logic [5:0]  b_q;
   logic [7:0]  sum_q;
   logic [31:0] len_q;
   logic        done_q;
   logic [7:0]  cur_byte;
   logic [7:0]  cur_len;
   logic        last_b;
   logic [7:0]  full_sum;

   assign cur_byte = tbl_byte(e_q, b_q, MEM_RANGE_LEN);
   assign cur_len  = ent_bytes(e_q);
   assign last_b   = ({2'b00, b_q} == cur_len - 8'd1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e_q    <= '0;
         b_q    <= '0;
         sum_q  <= '0;
         len_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q) begin
         sum_q <= sum_q + cur_byte;
         if (b_q == 6'd0) len_q <= len_q + {24'd0, cur_len};
         if (last_b) begin
            b_q <= '0;
            if (e_q == 3'(NUM_ENT - 1)) done_q <= 1'b1;
            else                        e_q    <= e_q + 3'd1;
         end else begin
            b_q <= b_q + 6'd1;
         end
      end
   end

   assign full_sum  = sum_q + len_q[7:0] + len_q[15:8] + len_q[23:16] + len_q[31:24];
   assign csum_o    = 8'd0 - full_sum;
   assign done_o    = done_q;
   assign tot_len_o = len_q;

   assert_done_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> done_q);
   assert_total_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> len_q == TOTAL);

endmodule

// File: rtl/attr_tbl_rom.sv
module attr_tbl_rom
   import attr_tbl_pkg::*;
#(
   parameter logic [63:0] MEM_RANGE_LEN = 64'h40000
) (
   input  logic [2:0]        ent_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [31:0]       tot_len_i,
   input  logic [7:0]        csum_i,
   output logic [31:0]       dword_o
);
   logic [31:0] raw;

   // one lane per byte of the dword, little-endian
   for (genvar i = 0; i < 4; i++) begin : g_lane
      assign raw[8*i +: 8] = tbl_byte(ent_i, {word_i, 2'(i)}, MEM_RANGE_LEN);
   end

   always_comb begin
      dword_o = raw;
      if (ent_i == 3'd0 && word_i == '0)       dword_o = tot_len_i;
      if (ent_i == 3'd0 && word_i == WORD_W'(1)) dword_o[15:8] = csum_i;
   end

endmodule

// File: rtl/attr_tbl_seq.sv
module attr_tbl_seq
   import attr_tbl_pkg::*;
#(
   parameter logic [15:0] VENDOR_ID = 16'h1E98,
   parameter logic [7:0]  OBJ_TYPE  = 8'h02
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en_i,
   input  logic                req_valid_i,
   output logic                req_ready_o,
   input  logic [HANDLE_W-1:0] req_handle_i,
   output logic                rsp_valid_o,
   input  logic                rsp_ready_i,
   output logic [31:0]         rsp_data_o,
   output logic                rsp_last_o,
   output logic [2:0]          ent_o,
   output logic [WORD_W-1:0]   word_o,
   input  logic [31:0]         ent_dword_i
);
   localparam logic [HANDLE_W-1:0] END_MARK = '1;

   logic                busy_q;
   logic [2:0]          ent_q;
   logic [HANDLE_W-1:0] next_q;
   logic [7:0]          len_q;
   logic [7:0]          cnt_q;
   logic                in_range;
   logic [7:0]          eb;
   logic                accept;
   logic                xfer;
   logic [7:0]          word_idx;

   assign in_range = req_handle_i < HANDLE_W'(NUM_ENT);
   assign eb       = ent_bytes(req_handle_i[2:0]);
   assign accept   = req_valid_i && req_ready_o;
   assign xfer     = rsp_valid_o && rsp_ready_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ent_q  <= '0;
         next_q <= '0;
         len_q  <= '0;
         cnt_q  <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         ent_q  <= req_handle_i[2:0];
         len_q  <= in_range ? 8'd2 + {2'b00, eb[7:2]} : 8'd2;
         next_q <= (req_handle_i < HANDLE_W'(NUM_ENT - 1)) ? req_handle_i + 1'b1 : END_MARK;
      end else if (xfer) begin
         if (cnt_q == len_q - 8'd1) busy_q <= 1'b0;
         else                       cnt_q  <= cnt_q + 8'd1;
      end
   end

   assign word_idx    = cnt_q - 8'd2;
   assign word_o      = word_idx[WORD_W-1:0];
   assign ent_o       = ent_q;
   assign req_ready_o = en_i && !busy_q;
   assign rsp_valid_o = busy_q;
   assign rsp_last_o  = busy_q && (cnt_q == len_q - 8'd1);

   always_comb begin
      case (cnt_q)
         8'd0:    rsp_data_o = {len_q, OBJ_TYPE, VENDOR_ID};
         8'd1:    rsp_data_o = {next_q, 8'h00, 8'h00};
         default: rsp_data_o = ent_dword_i;
      endcase
   end

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o) && $stable(rsp_last_o));
   assert_last_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_last_o |-> rsp_valid_o);
   assert_no_ready_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready_o && rsp_valid_o));
   assert_hdr_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o && cnt_q == 8'd0 |-> rsp_data_o[31:24] >= 8'd2 && rsp_data_o[31:24] <= 8'd12);

endmodule

// File: rtl/attr_tbl_resp.sv
module attr_tbl_resp
   import attr_tbl_pkg::*;
#(
   parameter logic [15:0] VENDOR_ID     = 16'h1E98,
   parameter logic [7:0]  OBJ_TYPE      = 8'h02,
   parameter logic [63:0] MEM_RANGE_LEN = 64'h40000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic [15:0] req_handle,
   output logic        rsp_valid,
   input  logic        rsp_ready,
   output logic [31:0] rsp_data,
   output logic        rsp_last
);
   if (HANDLE_W != 16) begin : g_bad_handle
      $error("handle width must be 16");
   end
   if (total_bytes() % 4 != 0) begin : g_bad_size
      $error("table size must be whole dwords");
   end

   logic              walk_done;
   logic [31:0]       tot_len;
   logic [7:0]        csum;
   logic [2:0]        ent;
   logic [WORD_W-1:0] word;
   logic [31:0]       ent_dword;

   attr_tbl_walker #(.MEM_RANGE_LEN(MEM_RANGE_LEN)) walker_i (
      .clk(clk), .rst_n(rst_n), .done_o(walk_done),
      .tot_len_o(tot_len), .csum_o(csum));

   attr_tbl_rom #(.MEM_RANGE_LEN(MEM_RANGE_LEN)) rom_i (
      .ent_i(ent), .word_i(word), .tot_len_i(tot_len),
      .csum_i(csum), .dword_o(ent_dword));

   attr_tbl_seq #(.VENDOR_ID(VENDOR_ID), .OBJ_TYPE(OBJ_TYPE)) seq_i (
      .clk(clk), .rst_n(rst_n), .en_i(walk_done),
      .req_valid_i(req_valid), .req_ready_o(req_ready), .req_handle_i(req_handle),
      .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data),
      .rsp_last_o(rsp_last), .ent_o(ent), .word_o(word), .ent_dword_i(ent_dword));

   assert_quiet_walk_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !walk_done |-> !req_ready && !rsp_valid);

endmodule

// File: tb/attr_tbl_resp_tb_top.sv
module attr_tbl_resp_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_handle = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [31:0] rsp_data;
   logic        rsp_last;

   always #(CLK_PERIOD/2) clk = ~clk;

   attr_tbl_resp dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_handle(req_handle), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_data(rsp_data), .rsp_last(rsp_last));

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [7:0]  ck;
   int          ready_mode = 0;
   logic [15:0] lfsr = 16'hACE1;
   int          extra_cnt = 0;
   int          rsp_idx = 0;
   int          pay_bytes = 0;
   logic [7:0]  pay_sum = 0;
   bit          held = 0;
   logic [31:0] held_data;
   logic        held_last;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int blen(input int e);
      case (e)
         0: return 16; 1, 2: return 24; 3: return 20;
         4: return 8;  5: return 24; 6: return 40;
         default: return 0;
      endcase
   endfunction

   function automatic logic [7:0] mbyte(input int e, input int b, input logic [7:0] c);
      if (e == 0) begin
         if (b == 0) return 8'd156;
         if (b == 4) return 8'd1;
         if (b == 5) return c;
         return 8'd0;
      end
      if (b == 0) return 8'(e - 1);
      if (b == 2) return 8'(blen(e));
      if (e == 1 && b == 18) return 8'h04;
      if (e == 6 && b >= 16 && ((b - 16) % 8 == 0 || (b - 16) % 8 == 2)) return 8'((b - 16) / 8);
      return 8'd0;
   endfunction

   function automatic logic [31:0] exp_dword(input int h, input int k);
      int n;
      n = (h < 7) ? 2 + blen(h) / 4 : 2;
      if (k == 0) return {8'(n), 8'h02, 16'h1E98};
      if (k == 1) return {(h < 6) ? 16'(h + 1) : 16'hFFFF, 16'h0000};
      return {mbyte(h, 4*(k-2)+3, ck), mbyte(h, 4*(k-2)+2, ck),
              mbyte(h, 4*(k-2)+1, ck), mbyte(h, 4*(k-2), ck)};
   endfunction

   function automatic string dw_tag(input int h, input int k);
      if (h >= 7) return "R7 out-of-range";
      if (k == 0) return "R5 header dword0";
      if (k == 1) return "R6 header dword1";
      if (h == 0) return "R3 R4 table header";
      if (h == 1 || h == 6) return "R9 default subtable";
      return "R2 R8 subtable bytes";
   endfunction

   task automatic send_req(input int h);
      int n;
      n = (h < 7) ? 2 + blen(h) / 4 : 2;
      @(posedge clk); #2;
      while (!req_ready) begin @(posedge clk); #2; end
      for (int k = 0; k < n; k++) begin
         exp_q.push_back(exp_dword(h, k));
         tag_q.push_back(dw_tag(h, k));
      end
      req_valid = 1'b1;
      req_handle = 16'(h);
      @(posedge clk); #2;
      req_valid = 1'b0;
   endtask

   task automatic drain();
      int guard = 0;
      while (exp_q.size() != 0 && guard < 2000) begin @(posedge clk); guard++; end
      chk(exp_q.size() == 0, "R11 response completes", 32'(exp_q.size()), 0);
   endtask

   // consumer ready pattern
   always @(posedge clk) begin
      #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (ready_mode)
         0: rsp_ready = 1'b1;
         1: rsp_ready = lfsr[0];
         default: rsp_ready = 1'b0;
      endcase
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (held && rsp_valid)
            chk(rsp_data == held_data && rsp_last == held_last, "R10 hold under stall", rsp_data, held_data);
         held = 0;
         if (rsp_valid && !rsp_ready) begin
            held = 1; held_data = rsp_data; held_last = rsp_last;
         end
         if (rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) begin
               extra_cnt++;
               chk(0, "R11 unexpected dword", rsp_data, 0);
            end else begin
               logic [31:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(rsp_data == e, t, rsp_data, e);
               chk(rsp_last == (exp_q.size() == 0), "R10 last flag", 32'(rsp_last), 32'(exp_q.size() == 0));
               if (rsp_idx >= 2) begin
                  pay_bytes += 4;
                  pay_sum = pay_sum + rsp_data[7:0] + rsp_data[15:8] + rsp_data[23:16] + rsp_data[31:24];
               end
               rsp_idx = (exp_q.size() == 0) ? 0 : rsp_idx + 1;
            end
         end
      end
   end

   task automatic report();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(0, "watchdog expired", 0, 0);
      report();
   end

   initial begin
      int waitc;
      int h;
      logic [7:0] s;
      s = 0;
      for (int e = 0; e < 7; e++)
         for (int b = 0; b < blen(e); b++) s = s + mbyte(e, b, 8'd0);
      ck = 8'd0 - s;

      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(!req_ready && !rsp_valid, "R1 reset state", {30'd0, req_ready, rsp_valid}, 0);
      @(posedge clk); #2;
      rst_n = 1'b1;
      waitc = 0;
      while (!req_ready && waitc < 400) begin
         if (waitc == 10) begin req_valid = 1'b1; req_handle = 16'd2; end
         if (waitc == 12) req_valid = 1'b0;
         chk(!rsp_valid, "R1 no response during walk", 32'(rsp_valid), 0);
         @(posedge clk); #2;
         waitc++;
      end
      chk(waitc >= 150 && waitc <= 170, "R1 walk duration", 32'(waitc), 156);

      // chained walk at full rate
      pay_bytes = 0; pay_sum = 0;
      h = 0;
      while (h != 16'hFFFF) begin
         send_req(h);
         drain();
         h = (h < 6) ? h + 1 : 16'hFFFF;
      end
      chk(pay_bytes == 156, "R3 chained byte total", 32'(pay_bytes), 156);
      chk(pay_sum == 0, "R4 table sums to zero", 32'(pay_sum), 0);

      // scrambled order under random stalls
      ready_mode = 1;
      send_req(6); drain();
      send_req(1); drain();
      send_req(0); drain();
      send_req(3); drain();
      send_req(4); drain();

      // out of range
      send_req(7); drain();
      send_req(8); drain();
      send_req(16'h1234); drain();
      send_req(16'hFFFF); drain();

      // request during a stalled response is dropped
      ready_mode = 2;
      send_req(6);
      repeat (3) begin
         req_valid = 1'b1; req_handle = 16'd4;
         chk(!req_ready, "R11 ready low while busy", 32'(req_ready), 0);
         @(posedge clk); #2;
      end
      req_valid = 1'b0;
      ready_mode = 0;
      drain();
      repeat (20) @(posedge clk);
      chk(extra_cnt == 0, "R11 single response", 32'(extra_cnt), 0);
      report();
   end

endmodule